// File: doc/BRIEF.md
# Probe-Byte Mode Estimator for Zero-Substitution Mismatch

This block watches the byte stream that a pattern synchroniser has already aligned. Once per pattern period the sender transmits one byte of all zeros. The synchroniser marks where that byte lands in the received stream. Each time the marked byte arrives, the block records the value that was actually received. A line element that cannot handle eight-zero substitution may decode the probe as some other value, such as 00011011. Bit errors and inconsistent handling of violations can also change the received value from one period to the next.

The block keeps one occurrence counter for every possible byte value. It reports the value received most often, which is the maximum-likelihood estimate of how the path decodes the probe, together with that value's count. A separate flag shows whether the estimate is nonzero, which indicates a mismatch. Counting happens only while the synchroniser reports lock. Losing lock clears all counters, so that the next lock starts a new measurement. A hold input freezes the result without clearing it.

Top module: `b8zs_mode_est`

## Requirements
- R1: After reset, `mode_sym` is 0x00, `mode_cnt` is 0, `est_valid` is 0 and `mismatch` is 0.
- R2: A byte is counted only in a cycle where `sym_vld`, `frame_start` and `locked` are all 1 and `hold` is 0. In every other cycle the outputs keep their values while `locked` is 1.
- R3: One clock edge after a counted byte, `mode_sym` is the byte value with the largest number of counted occurrences, and `mode_cnt` is that number.
- R4: When a different value reaches the same count as the current mode, the current mode is kept. The mode changes only when another value's count strictly exceeds it.
- R5: In any cycle where `locked` is 0, all counters clear. From the next edge, `mode_cnt` is 0, `mode_sym` is 0x00 and `est_valid` is 0.
- R6: While `hold` is 1, marked bytes are not counted and all outputs keep their values.
- R7: `mismatch` is 1 exactly when `est_valid` is 1 and `mode_sym` is not 0x00. A mode of 0x00 reports no mismatch.
- R8: Every counter saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R9: `est_valid` stays 0 until at least one byte has been counted since reset or since the last loss of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_vld | input | 1 | A received byte is present on `sym_in` this cycle |
| sym_in | input | SYM_W | Received byte |
| frame_start | input | 1 | This byte sits at the probe position of the pattern |
| locked | input | 1 | The pattern synchroniser is locked |
| hold | input | 1 | Freeze the estimate; stop counting |
| mode_sym | output | SYM_W | Most frequently received probe value |
| mode_cnt | output | CNT_W | Occurrence count of `mode_sym` |
| est_valid | output | 1 | At least one probe has been counted |
| mismatch | output | 1 | The estimate is valid and nonzero |

## Verification
The properties assume that `locked` and `hold` are clean, registered levels. They also assume that `frame_start` means something only while `sym_vld` is 1, so that a stable output can be attributed to the absence of a qualified sample. The stimulus drives every input on the falling edge and holds it for whole cycles. It marks probe bytes back to back, so counts build quickly. It leaves `locked` high except during the deliberate clearing scenario, which means the stability properties are exercised over long spans in which no byte is counted.

// File: rtl/b8zs_mode_pkg.sv
// Package: shared sizing for the probe-byte mode estimator.
// Assumes: symbol width small enough that one counter per value is affordable.
package b8zs_mode_pkg;
    localparam int unsigned DEF_SYM_W = 8;
    localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/mode_cnt_bank.sv
// Module: one saturating occurrence counter per symbol value.
// Provides the incremented (saturated) count of the addressed symbol combinationally
// and commits it on inc_en. Assumes clr and inc_en are never both meaningful at once
// (clr wins).
module mode_cnt_bank #(
    parameter int unsigned SYM_W = b8zs_mode_pkg::DEF_SYM_W,
    parameter int unsigned CNT_W = b8zs_mode_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [SYM_W-1:0] idx,
    output logic [CNT_W-1:0] nxt_cnt
);
    localparam int unsigned DEPTH = 1 << SYM_W;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [DEPTH];

    // Next value of the addressed counter, held at its ceiling.
    always_comb begin
        if (cnt_q[idx] == CMAX) nxt_cnt = CMAX;
        else                    nxt_cnt = cnt_q[idx] + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One counter: clears on reset or clear, advances when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q[g] <= '0;
            else if (inc_en && (idx == SYM_W'(g)))
                cnt_q[g] <= nxt_cnt;
        end
    end
endmodule

// File: rtl/mode_tracker.sv
// Module: incremental running maximum over the counter bank.
// Assumes every counter update passes through here, so the held best count always
// equals the bank count of best_sym and no other count exceeds it.
// Ties keep the current leader (strictly-greater replacement).
module mode_tracker #(
    parameter int unsigned SYM_W = b8zs_mode_pkg::DEF_SYM_W,
    parameter int unsigned CNT_W = b8zs_mode_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [SYM_W-1:0] idx,
    input  logic [CNT_W-1:0] cand_cnt,
    output logic [SYM_W-1:0] best_sym,
    output logic [CNT_W-1:0] best_cnt,
    output logic             seen
);
    // Keep the leader and whether anything has been counted.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_sym <= '0;
            best_cnt <= '0;
            seen     <= 1'b0;
        end else if (upd) begin
            seen <= 1'b1;
            if (cand_cnt > best_cnt) begin
                best_sym <= idx;
                best_cnt <= cand_cnt;
            end
        end
    end
endmodule

// File: rtl/b8zs_mode_est.sv
// Module: probe-byte mode estimator (top).
// Counts received values of the marked probe byte while locked, reports the most
// frequent one and flags it when nonzero. Assumes frame_start is qualified by sym_vld
// and that locked low for one cycle is enough to start a fresh measurement.
module b8zs_mode_est #(
    parameter int unsigned SYM_W = b8zs_mode_pkg::DEF_SYM_W,
    parameter int unsigned CNT_W = b8zs_mode_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_vld,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             frame_start,
    input  logic             locked,
    input  logic             hold,
    output logic [SYM_W-1:0] mode_sym,
    output logic [CNT_W-1:0] mode_cnt,
    output logic             est_valid,
    output logic             mismatch
);
    logic             take;
    logic             wipe;
    logic [CNT_W-1:0] cand;

    // Qualify a probe sample and the clear request.
    always_comb begin
        take = sym_vld && frame_start && locked && !hold;
        wipe = !locked;
    end

    mode_cnt_bank #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wipe),
        .inc_en  (take),
        .idx     (sym_in),
        .nxt_cnt (cand)
    );

    mode_tracker #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wipe),
        .upd      (take),
        .idx      (sym_in),
        .cand_cnt (cand),
        .best_sym (mode_sym),
        .best_cnt (mode_cnt),
        .seen     (est_valid)
    );

    // Nonzero estimate means the path mangles the all-zero probe.
    always_comb mismatch = est_valid && (mode_sym != '0);
endmodule

// File: rtl/b8zs_mode_est_chk.sv
// Checker: temporal properties of the mode estimator, bound to the top.
module b8zs_mode_est_chk #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_vld,
    input logic             frame_start,
    input logic             locked,
    input logic             hold,
    input logic [SYM_W-1:0] mode_sym,
    input logic [CNT_W-1:0] mode_cnt,
    input logic             est_valid,
    input logic             mismatch
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R5
    clear_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (!est_valid && mode_cnt == '0 && mode_sym == '0));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(sym_vld && frame_start && !hold)) |=>
            ($stable(mode_cnt) && $stable(mode_sym) && $stable(est_valid)));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && hold) |=> ($stable(mode_cnt) && $stable(mode_sym)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && sym_vld && frame_start && !hold && mode_cnt != CMAX) |=>
            (mode_cnt == $past(mode_cnt) || mode_cnt == $past(mode_cnt) + 1'b1));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mode_cnt == CMAX) |=> (!locked || mode_cnt == CMAX));

    // R9
    valid_has_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> (mode_cnt != '0));

    // R7
    no_flag_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !est_valid |-> !mismatch);
endmodule

bind b8zs_mode_est b8zs_mode_est_chk #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_vld     (sym_vld),
    .frame_start (frame_start),
    .locked      (locked),
    .hold        (hold),
    .mode_sym    (mode_sym),
    .mode_cnt    (mode_cnt),
    .est_valid   (est_valid),
    .mismatch    (mismatch)
);

// File: tb/b8zs_mode_est_test.sv
module b8zs_mode_est_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_vld = 1'b0;
    logic [7:0]  sym_in = '0;
    logic        frame_start = 1'b0;
    logic        locked = 1'b0;
    logic        hold = 1'b0;
    logic [7:0]  mode_sym;
    logic [15:0] mode_cnt;
    logic        est_valid;
    logic        mismatch;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    b8zs_mode_est uut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_in(sym_in),
        .frame_start(frame_start), .locked(locked), .hold(hold),
        .mode_sym(mode_sym), .mode_cnt(mode_cnt), .est_valid(est_valid),
        .mismatch(mismatch)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one marked probe byte for one cycle; on return outputs reflect it.
    task automatic probe(input logic [7:0] b);
        @(negedge clk);
        sym_vld = 1'b1; frame_start = 1'b1; sym_in = b;
        @(negedge clk);
        sym_vld = 1'b0; frame_start = 1'b0;
    endtask

    task automatic relock();
        @(negedge clk); locked = 1'b0;
        @(negedge clk); locked = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 mode_sym", mode_sym, 0);
        check("R1 mode_cnt", mode_cnt, 0);
        check("R1/R9 est_valid", est_valid, 0);
        check("R1 mismatch", mismatch, 0);
    endtask

    task automatic t_clean();
        relock();
        check("R9 valid before sample", est_valid, 0);
        for (int i = 0; i < 5; i++) probe(8'h00);
        check("R3 clean mode", mode_sym, 0);
        check("R3 clean count", mode_cnt, 5);
        check("R9 valid after sample", est_valid, 1);
        check("R7 zero mode no mismatch", mismatch, 0);
    endtask

    task automatic t_mismatch();
        relock();
        probe(8'h00); probe(8'h1B); probe(8'h00); probe(8'h1B);
        check("R4 tie keeps mode", mode_sym, 8'h00);
        check("R4 tie count", mode_cnt, 2);
        probe(8'h1D);
        probe(8'h1B);
        check("R3 new leader", mode_sym, 8'h1B);
        check("R3 leader count", mode_cnt, 3);
        check("R7 mismatch set", mismatch, 1);
    endtask

    task automatic t_ignored();
        // State: mode 0x1B, count 3.
        @(negedge clk); sym_vld = 1'b1; frame_start = 1'b0; sym_in = 8'h1D;
        @(negedge clk); sym_vld = 1'b0; frame_start = 1'b1; sym_in = 8'h1D;
        @(negedge clk); frame_start = 1'b0;
        check("R2 unmarked ignored cnt", mode_cnt, 3);
        check("R2 unmarked ignored sym", mode_sym, 8'h1B);
        // Two more 0x1D would make it lead if any had counted.
        probe(8'h1D);
        check("R2 only marked counted", mode_sym, 8'h1B);
        check("R2 count kept", mode_cnt, 3);
    endtask

    task automatic t_hold();
        @(negedge clk); hold = 1'b1;
        probe(8'h1D); probe(8'h1D); probe(8'h1D);
        check("R6 hold sym", mode_sym, 8'h1B);
        check("R6 hold cnt", mode_cnt, 3);
        @(negedge clk); hold = 1'b0;
        probe(8'h1D);
        check("R6 released: 1D at 3 ties", mode_sym, 8'h1B);
        probe(8'h1D);
        check("R6 released counting", mode_sym, 8'h1D);
        check("R6 released count", mode_cnt, 4);
    endtask

    task automatic t_unlock();
        @(negedge clk); locked = 1'b0;
        sym_vld = 1'b1; frame_start = 1'b1; sym_in = 8'h1D;
        @(negedge clk);
        sym_vld = 1'b0; frame_start = 1'b0;
        check("R5 count cleared", mode_cnt, 0);
        check("R5 valid cleared", est_valid, 0);
        check("R5 sym cleared", mode_sym, 0);
        check("R7 no flag when empty", mismatch, 0);
        @(negedge clk); locked = 1'b1;
        probe(8'h42);
        check("R5 fresh start count", mode_cnt, 1);
        check("R5 fresh start sym", mode_sym, 8'h42);
    endtask

    task automatic t_sat();
        relock();
        @(negedge clk); sym_vld = 1'b1; frame_start = 1'b1; sym_in = 8'h55;
        repeat (65540) @(negedge clk);
        sym_vld = 1'b0; frame_start = 1'b0;
        check("R8 saturated", mode_cnt, 65535);
        check("R8 sym", mode_sym, 8'h55);
        probe(8'h55);
        check("R8 no wrap", mode_cnt, 65535);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        locked = 1'b1;
        t_clean();
        t_mismatch();
        t_ignored();
        t_hold();
        t_unlock();
        t_sat();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule